// File: doc/BRIEF.md
# Tagged-Command I2C Master Engine

This block is an I2C bus master driven by a queue of 16-bit command entries instead of per-bit register writes. Software pushes entries into a command FIFO. Bits [15:8] of each entry hold a tag and bits [7:0] hold a byte or a count. The engine pops the entries one at a time. It produces START, address, data and STOP conditions on open-drain SCL and SDA through the `scl_oe` and `sda_oe` pull-down enables. A read is one counted receive entry: it clocks in the requested bytes, pushes them into a receive FIFO, NACKs the final byte and closes the transfer with a STOP without further help.

The state machine has six states:
- `S_IDLE`: the bus is free and both lines are released.
- `S_WAIT`: the bus is owned, SCL is held low and the engine waits for the next entry.
- `S_START`: three half-periods. SDA is released, then SCL is released, then SDA is pulled low.
- `S_BYTE`: eighteen half-periods, covering 8 data bits and 1 acknowledge bit.
- `S_STOP`: three half-periods. SDA is pulled low, then SCL is released, then SDA is released.
- `S_FLUSH`: discards queued entries after a NACK.

The transitions are:
- decode-start: `S_IDLE` or `S_WAIT` to `S_START`.
- decode-byte: `S_WAIT` to `S_BYTE`.
- start-done: `S_START` to `S_BYTE`.
- byte-hold: `S_BYTE` to `S_WAIT`.
- byte-next: `S_BYTE` to `S_BYTE`, between received bytes.
- byte-stop: `S_BYTE` to `S_STOP`.
- stop-done: `S_STOP` to `S_IDLE`.
- stop-flush: `S_STOP` to `S_FLUSH`.
- flush-done: `S_FLUSH` to `S_IDLE`.

Arbitration, clock stretching, multi-master operation and high-speed mode are not supported.

Top module: `tagi2c_master`

## Requirements
- R1: An entry with tag 1 (bits [15:8] = 1) issues a START. It then sends bits [7:0], MSB first, as the address byte, which is the 7-bit address shifted left with bit 0 set for a read. Executing a tag-1 entry clears status bits 3 and 2.
- R2: A tag-2 entry sends its low byte. The engine then keeps the bus, holding SCL low, until the next entry arrives. A tag-1 entry that arrives while the bus is held produces a repeated START.
- R3: A tag-3 entry sends its low byte and then issues a STOP. After the STOP, SCL and SDA are both released.
- R4: A tag-4 entry receives N bytes, where N is the low byte and 0 stands for 256. The bytes enter the receive FIFO in bus order. The master ACKs every byte except the last, NACKs the last, and then issues a STOP.
- R5: When a transmitted byte is NACKed, the engine sets status bit 3 and issues a STOP. It then discards every entry still queued and returns to idle, leaving status bit 2 clear.
- R6: Some entries are discarded without any bus activity and set status bit 2 (error):
  - any entry other than tag 1 while the bus is free;
  - any tag outside 1..4 while the bus is held.
- R7: Status bit 0 is 1 while the command FIFO holds CMD_DEPTH entries. Status bit 8 is 1 from the decode of a START entry until the STOP completes. Status bits 7..4 and bit 1 are always 0.
- R8: Each SCL half-period lasts fs_div + 3 clock cycles, so the SCL period inside a byte is 2*(fs_div + 3) cycles.
- R9: SDA changes only while SCL is low, except when forming a START or a STOP. Each byte takes exactly 9 SCL pulses.
- R10: After reset, both lines are released, the status word is 0 and the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_push | input | 1 | Write `cmd_entry` into the command FIFO |
| cmd_entry | input | 16 | Tag in [15:8], byte or count in [7:0] |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_byte | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| fs_div | input | 8 | SCL divider; half-period is fs_div+3 cycles |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status | output | 9 | [8] bus owned, [3] NACK seen, [2] error, [0] command FIFO full |

## Verification
A wrong phase counter or state shows up on the bus within one half-period. It appears as an extra or missing SCL pulse, an SDA edge while SCL is high that decodes as a spurious START or STOP, or a shifted byte value, and the bus monitor compares every decoded event against the expected queue. Corrupted byte-count or receive-path state appears at the receive FIFO as a wrong byte, or as the master's NACK landing on the wrong byte. A flush that fails leaves entries behind. The next one is then decoded from idle and raises the error bit, which is checked right after each NACK.

// File: rtl/tagi2c_pkg.sv
package tagi2c_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_START, S_BYTE, S_STOP, S_FLUSH
    } state_t;

    localparam logic [7:0] TAG_START     = 8'd1;
    localparam logic [7:0] TAG_SEND      = 8'd2;
    localparam logic [7:0] TAG_SEND_STOP = 8'd3;
    localparam logic [7:0] TAG_RECV      = 8'd4;

    localparam int ST_FULL = 0;
    localparam int ST_ERR  = 2;
    localparam int ST_NACK = 3;
    localparam int ST_BUS  = 8;
    localparam int ST_W    = 9;
endpackage

// File: rtl/tagi2c_fifo.sv
module tagi2c_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   used;
    logic          do_push, do_pop;

    assign empty   = (used == '0);
    assign full    = (used == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      used <= used + 1'b1;
            else if (do_pop && !do_push) used <= used - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/tagi2c_halfper.sv
module tagi2c_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             first
);
    localparam int CW = DIV_W + 1;
    logic [CW-1:0] cnt;

    assign tick  = (cnt == ({1'b0, div} + CW'(2)));
    assign first = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tagi2c_master.sv
module tagi2c_master
    import tagi2c_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int RX_DEPTH  = 8,
    parameter int DIV_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_push,
    input  logic [15:0]      cmd_entry,
    input  logic             rx_pop,
    output logic [7:0]       rx_byte,
    output logic             rx_empty,
    input  logic [DIV_W-1:0] fs_div,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [ST_W-1:0]  status
);
    localparam logic [4:0] PH_LAST  = 5'd17;
    localparam logic [3:0] ACK_BIT  = 4'd8;
    localparam logic [1:0] EDGE_END = 2'd2;

    state_t      state, state_n;
    logic [4:0]  ph;
    logic [3:0]  bitn;
    logic        hi;
    logic [7:0]  txb, rxb;
    logic [8:0]  left;
    logic        rd_mode, stop_after, nack_q, err_q, flush_q;
    logic        tick, first, restart;
    logic [15:0] cmd_head;
    logic [7:0]  tag, arg;
    logic        cmd_empty, cmd_full, cmd_pop;
    logic        rx_push, rx_full;
    logic        can_take, valid_tag, byte_end;

    tagi2c_fifo #(.W(16), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_entry),
        .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full));

    tagi2c_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rxb),
        .pop(rx_pop), .dout(rx_byte), .empty(rx_empty), .full(rx_full));

    tagi2c_halfper #(.DIV_W(DIV_W)) u_half (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(fs_div),
        .tick(tick), .first(first));

    assign tag       = cmd_head[15:8];
    assign arg       = cmd_head[7:0];
    assign bitn      = ph[4:1];
    assign hi        = ph[0];
    assign can_take  = (state == S_IDLE || state == S_WAIT) && !cmd_empty;
    assign valid_tag = (state == S_IDLE) ? (tag == TAG_START)
                                         : (tag >= TAG_START && tag <= TAG_RECV);
    assign cmd_pop   = can_take || (state == S_FLUSH && !cmd_empty);
    assign byte_end  = (state == S_BYTE) && tick && (ph == PH_LAST);
    assign rx_push   = byte_end && rd_mode;
    assign restart   = (state == S_IDLE || state == S_WAIT) && (state_n != state);

    always_comb begin
        status          = '0;
        status[ST_FULL] = cmd_full;
        status[ST_ERR]  = err_q;
        status[ST_NACK] = nack_q;
        status[ST_BUS]  = (state != S_IDLE) && (state != S_FLUSH);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (can_take && valid_tag) state_n = S_START;
            S_WAIT:  if (can_take && valid_tag)
                         state_n = (tag == TAG_START) ? S_START : S_BYTE;
            S_START: if (tick && ph[1:0] == EDGE_END) state_n = S_BYTE;
            S_BYTE:  if (byte_end) begin
                         if (rd_mode)         state_n = (left == 9'd1) ? S_STOP : S_BYTE;
                         else if (sda_in)     state_n = S_STOP;
                         else if (stop_after) state_n = S_STOP;
                         else                 state_n = S_WAIT;
                     end
            S_STOP:  if (tick && ph[1:0] == EDGE_END) state_n = flush_q ? S_FLUSH : S_IDLE;
            S_FLUSH: if (cmd_empty) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0; txb <= '0; rxb <= '0; left <= '0;
            rd_mode <= 1'b0; stop_after <= 1'b0;
            nack_q <= 1'b0; err_q <= 1'b0; flush_q <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
            if (rx_push && rx_full) err_q <= 1'b1;
            unique case (state)
                S_IDLE, S_WAIT: begin
                    if (can_take) begin
                        if (!valid_tag) begin
                            err_q <= 1'b1;
                        end else if (tag == TAG_START) begin
                            txb <= arg; rd_mode <= 1'b0; stop_after <= 1'b0;
                            nack_q <= 1'b0; err_q <= 1'b0; sda_oe <= 1'b0; ph <= '0;
                        end else if (tag == TAG_RECV) begin
                            left <= (arg == 8'd0) ? 9'd256 : {1'b0, arg};
                            rd_mode <= 1'b1; ph <= '0;
                        end else begin
                            txb <= arg; rd_mode <= 1'b0; ph <= '0;
                            stop_after <= (tag == TAG_SEND_STOP);
                        end
                    end
                end
                S_START: if (tick) begin
                    ph <= ph + 1'b1;
                    if (ph[1:0] == 2'd0) scl_oe <= 1'b0;
                    if (ph[1:0] == 2'd1) sda_oe <= 1'b1;
                    if (ph[1:0] == EDGE_END) begin scl_oe <= 1'b1; ph <= '0; end
                end
                S_BYTE: begin
                    if (!hi && first)
                        sda_oe <= rd_mode ? (bitn == ACK_BIT && left != 9'd1)
                                          : (bitn != ACK_BIT && !txb[7]);
                    if (tick && !hi) begin
                        scl_oe <= 1'b0;
                        ph     <= ph + 1'b1;
                    end else if (tick) begin
                        scl_oe <= 1'b1;
                        if (bitn != ACK_BIT) begin
                            rxb <= {rxb[6:0], sda_in};
                            txb <= {txb[6:0], 1'b0};
                        end
                        if (ph == PH_LAST) begin
                            ph <= '0;
                            if (rd_mode) left <= left - 1'b1;
                            else if (sda_in) begin nack_q <= 1'b1; flush_q <= 1'b1; end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                S_STOP: begin
                    if (first && ph == 5'd0) sda_oe <= 1'b1;
                    if (tick) begin
                        ph <= ph + 1'b1;
                        if (ph[1:0] == 2'd0) scl_oe <= 1'b0;
                        if (ph[1:0] == 2'd1) sda_oe <= 1'b0;
                        if (ph[1:0] == EDGE_END) ph <= '0;
                    end
                end
                S_FLUSH: if (cmd_empty) flush_q <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tagi2c_chk.sv
module tagi2c_chk
    import tagi2c_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input state_t state,
    input logic   scl_oe,
    input logic   sda_oe,
    input logic   nack_q,
    input logic   cmd_pop,
    input logic   cmd_empty,
    input logic   rx_push
);
    // R9: outside START/STOP forming, SDA moves only with SCL held low
    p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) && state != S_START && state != S_STOP
        |-> scl_oe && $past(scl_oe));

    // R3: idle bus has both lines released
    p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_FLUSH) |-> !scl_oe && !sda_oe);

    // R5: a NACK leads straight into the STOP sequence
    p_nack_to_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> state == S_STOP);

    // R6: entries are only consumed from a non-empty queue
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> !cmd_empty);

    // R4: received bytes are stored at the end of a byte with SCL high
    p_rx_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> state == S_BYTE && !scl_oe);
endmodule

bind tagi2c_master tagi2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .nack_q(nack_q), .cmd_pop(cmd_pop), .cmd_empty(cmd_empty), .rx_push(rx_push));

// File: tb/sim_tagi2c_master.sv
`timescale 1ns/1ps
module sim_tagi2c_master;
    localparam logic [6:0] TADDR = 7'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 1'b0;
    logic [15:0] cmd_entry = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_empty;
    logic [7:0]  cur_div = 8'd0;
    logic        scl_oe, sda_oe;
    logic [8:0]  status;
    logic        t_drv = 1'b0;
    logic        sda_line;

    int checks = 0;
    int errors = 0;

    logic [10:0] exp_q [$];
    string       exp_r [$];
    logic [7:0]  rx_exp [$];

    assign sda_line = !(sda_oe || t_drv);

    always #2.5 clk = ~clk;

    tagi2c_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_entry(cmd_entry),
        .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty), .fs_div(cur_div),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] kind, input logic ack,
                             input logic [7:0] b, input string req);
        exp_q.push_back({kind, ack, b});
        exp_r.push_back(req);
    endtask

    task automatic push(input logic [7:0] tg, input logic [7:0] val);
        cmd_push  = 1'b1;
        cmd_entry = {tg, val};
        @(negedge clk);
        cmd_push  = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (exp_q.size() != 0 || status[8] || rx_exp.size() != 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_read(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            expect_ev(2'd2, (i == n - 1), 8'(8'h30 + i), req);
            rx_exp.push_back(8'(8'h30 + i));
        end
    endtask

    // scoreboard: pop the receive FIFO and compare
    always @(negedge clk) begin
        rx_pop = 1'b0;
        if (rst_n && !rx_empty) begin
            if (rx_exp.size() == 0) check(1'b0, "R4 unexpected rx byte", rx_byte, 0);
            else begin
                logic [7:0] e;
                e = rx_exp.pop_front();
                check(rx_byte == e, "R4 rx byte", rx_byte, e);
            end
            rx_pop = 1'b1;
        end
    end

    // bus monitor and target model
    bit         p_scl = 1'b1, p_sda = 1'b1;
    int         bitn = 0;
    bit         is_addr = 1'b0, reading = 1'b0;
    logic [7:0] sh = '0;
    logic [7:0] rd_val = 8'h30;
    int         cyc = 0, last_rise = 0;

    task automatic got(input logic [10:0] ev);
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected bus event", ev, 0);
        else begin
            logic [10:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            check(ev == e, r, ev, e);
        end
    endtask

    always @(negedge clk) begin
        bit scl_l, sda_l;
        scl_l = !scl_oe;
        sda_l = sda_line;
        cyc++;
        if (rst_n) begin
            if (scl_l && p_scl && p_sda && !sda_l) begin
                got({2'd0, 1'b0, 8'h00});
                bitn = 0; is_addr = 1'b1; reading = 1'b0; t_drv = 1'b0;
            end else if (scl_l && p_scl && !p_sda && sda_l) begin
                got({2'd1, 1'b0, 8'h00});
                reading = 1'b0;
            end else if (scl_l && !p_scl) begin
                if (bitn == 8) begin
                    check(cyc - last_rise == 2 * (int'(cur_div) + 3),
                          "R8 scl period", cyc - last_rise, 2 * (int'(cur_div) + 3));
                    got({2'd2, sda_l, sh});
                    if (is_addr) begin
                        reading = sh[0] && !sda_l;
                        rd_val  = 8'h30;
                        is_addr = 1'b0;
                    end else if (reading) begin
                        if (!sda_l) rd_val = rd_val + 1'b1;
                        else        reading = 1'b0;
                    end
                    bitn = 0;
                end else begin
                    sh = {sh[6:0], sda_l};
                    bitn++;
                end
                last_rise = cyc;
            end else if (!scl_l && p_scl) begin
                if (reading) t_drv = (bitn < 8) ? !rd_val[3'(7 - bitn)] : 1'b0;
                else t_drv = (bitn == 8) && (is_addr ? (sh[7:1] == TADDR) : (sh != 8'hFF));
            end
        end
        p_scl = scl_l;
        p_sda = sda_l;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(status == 9'd0, "R10 status after reset", status, 0);
        check(!scl_oe && !sda_oe, "R10 lines after reset", {scl_oe, sda_oe}, 0);
        check(rx_empty, "R10 rx empty after reset", rx_empty, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: plain write, fastest divider
        cur_div = 8'd0;
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h54, "R1 address byte");
        expect_ev(2'd2, 1'b0, 8'h11, "R2 data byte");
        expect_ev(2'd2, 1'b0, 8'h22, "R3 last data byte");
        expect_ev(2'd1, 1'b0, 8'h00, "R3 stop");
        push(8'd1, 8'h54); push(8'd2, 8'h11); push(8'd3, 8'h22);
        repeat (5) @(negedge clk);
        check(status[8], "R7 bus bit during transfer", status[8], 1);
        wait_done();
        check(!scl_oe && !sda_oe, "R3 lines released", {scl_oe, sda_oe}, 0);
        check(status == 9'd0, "R7 status after write", status, 0);

        // R2 R4: write, repeated start, 3-byte read, slower divider
        cur_div = 8'd5;
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h54, "R1 address byte");
        expect_ev(2'd2, 1'b0, 8'h07, "R2 data byte");
        expect_ev(2'd0, 1'b0, 8'h00, "R2 repeated start");
        expect_ev(2'd2, 1'b0, 8'h55, "R1 read address");
        expect_read(3, "R4 received byte");
        expect_ev(2'd1, 1'b0, 8'h00, "R4 stop after read");
        push(8'd1, 8'h54); push(8'd2, 8'h07); push(8'd1, 8'h55); push(8'd4, 8'd3);
        wait_done();

        // R4 single-byte read
        cur_div = 8'd2;
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h55, "R1 read address");
        expect_read(1, "R4 single byte nacked");
        expect_ev(2'd1, 1'b0, 8'h00, "R4 stop");
        push(8'd1, 8'h55); push(8'd4, 8'd1);
        wait_done();

        // R5: address NACK flushes the rest
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b1, 8'h20, "R5 address nacked");
        expect_ev(2'd1, 1'b0, 8'h00, "R5 stop after nack");
        push(8'd1, 8'h20); push(8'd2, 8'h01); push(8'd3, 8'h02);
        wait_done();
        check(status[3], "R5 nack bit", status[3], 1);
        check(!status[2], "R5 queue flushed, no error", status[2], 0);

        // R5: data NACK
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h54, "R1 address byte");
        expect_ev(2'd2, 1'b1, 8'hFF, "R5 data nacked");
        expect_ev(2'd1, 1'b0, 8'h00, "R5 stop after nack");
        push(8'd1, 8'h54); push(8'd2, 8'hFF); push(8'd3, 8'h01);
        wait_done();
        check(status[3] && !status[2], "R5 data nack status", status[3:2], 2);

        // R6: non-start entry while bus free
        push(8'd2, 8'h33);
        repeat (60) @(negedge clk);
        check(status[2], "R6 error bit", status[2], 1);
        check(!status[8] && !scl_oe && !sda_oe, "R6 no bus activity",
              {status[8], scl_oe, sda_oe}, 0);
        push(8'd9, 8'h33);
        repeat (20) @(negedge clk);
        check(!scl_oe && !sda_oe && exp_q.size() == 0, "R6 unknown tag ignored",
              {scl_oe, sda_oe}, 0);

        // R7: command FIFO full, R1 clearing of nack/error
        cur_div = 8'd20;
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h54, "R1 address byte");
        for (int i = 0; i < 7; i++) expect_ev(2'd2, 1'b0, 8'(8'h40 + i), "R2 queued byte");
        expect_ev(2'd2, 1'b0, 8'h4F, "R3 last byte");
        expect_ev(2'd1, 1'b0, 8'h00, "R3 stop");
        push(8'd1, 8'h54);
        for (int i = 0; i < 7; i++) push(8'd2, 8'(8'h40 + i));
        push(8'd3, 8'h4F);
        check(status[0], "R7 full bit", status[0], 1);
        check(status[3:2] == 2'b00, "R1 start clears nack and error", status[3:2], 0);
        check((status & 9'h0F2) == 9'd0, "R7 reserved bits zero", status, 0);
        repeat (500) @(negedge clk);
        check(!status[0], "R7 full bit clears", status[0], 0);
        wait_done();

        // R4: count 0 means 256
        cur_div = 8'd0;
        expect_ev(2'd0, 1'b0, 8'h00, "R1 start");
        expect_ev(2'd2, 1'b0, 8'h55, "R1 read address");
        expect_read(256, "R4 count zero byte");
        expect_ev(2'd1, 1'b0, 8'h00, "R4 stop after 256");
        push(8'd1, 8'h55); push(8'd4, 8'd0);
        wait_done();
        check(rx_empty && !status[8], "R4 read of 256 complete", {rx_empty, status[8]}, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule